// File: doc/BRIEF.md
# I2C master bus-event sequencer

This block is the bus engine of an I2C master. Software runs the bus one event at a time by writing a single command bit: open the bus with a Start, reopen it with a Repeated Start, close it with a Stop, clock in one byte, or run the acknowledge pulse that follows a received byte. A separate write of a byte to the transmit port sends it and collects the slave's answer. Each command bit stays set in `cmd_bits` while its sequence runs and clears by itself when the sequence ends. Only one sequence runs at a time. A write that arrives while the engine is busy is dropped and raises a collision flag.

The engine does not drive the pads. Instead it asserts drive-low enables `sda_lo` and `scl_lo` and reads the resolved line levels back on `sda_in` and `scl_in`. Every SCL phase, low or high, lasts `baud`+1 system clocks. A high phase starts counting only once the resolved SCL is actually high, so a slave that holds SCL low pauses the engine.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, `sda_lo`, `scl_lo`, `busy`, `cmd_bits`, `wcol`, `done`, `nack` and `rx_data` are all 0.
- R2: When idle with `master_en`=1, a command write is accepted if `cmd_wdata` has exactly one bit set. The bits are: bit0 Start, bit1 Repeated Start, bit2 Stop, bit3 receive, bit4 acknowledge. From the next cycle the same bit shows in `cmd_bits` and `busy` is 1. For Start, SDA is pulled low while SCL is high, then SCL is pulled low, and both stay held low afterwards.
- R3: Repeated Start takes 4 phases. SDA is released, then SCL is released, then SDA falls while SCL is high, then SCL is pulled low.
- R4: Stop takes 3 phases. With SCL low, SDA is pulled low, then SCL is released, then SDA is released while SCL is high. Both lines are left released.
- R5: Receive gives 8 SCL pulses with SDA released. At the end of each high phase the SDA level is shifted in, MSB first. `rx_data` holds the byte once the sequence ends.
- R6: Acknowledge gives one SCL pulse. SDA carries the value of `ack_data` taken at the accepting edge: 1 releases SDA (NACK) and 0 drives it low (ACK).
- R7: A `tx_we` write while idle with `master_en`=1 and `cmd_we`=0 gives 9 SCL pulses. The first 8 send `tx_data` MSB first. On the ninth, SDA is released and its level at the end of that high phase is stored in `nack` (0 means the slave acknowledged).
- R8: `done` is high for exactly one cycle at the end of a transmit, receive or acknowledge sequence, in the same cycle that `busy` first reads 0. It stays 0 for Start, Repeated Start and Stop.
- R9: A write (`cmd_we` or `tx_we`) with `master_en`=1 while busy is ignored and sets `wcol`. So is an idle command write whose `cmd_wdata` does not have exactly one bit set. An accepted write clears `wcol`.
- R10: With `master_en`=0, writes have no effect: `busy` stays 0 and `wcol` is unchanged.
- R11: Each phase lasts `baud`+1 clocks. Counted from the accepting edge, `busy` drops and the command bit clears at the edge that ends the last phase. The phase counts are Start 2, Repeated Start 4, Stop 3, receive 16, acknowledge 2, transmit 18.
- R12: In a high phase, while `scl_in` is low, the engine holds its outputs and its state. The `baud`+1 count of that phase starts at the first edge at which `scl_in` is seen high.
- R13: During data and acknowledge pulses, SDA changes only while SCL is low. No Start or Stop condition appears on the bus during a transmit or receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | Master mode; writes are ignored when 0 |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 5 | Command bits: 0 Start, 1 Repeated Start, 2 Stop, 3 receive, 4 acknowledge |
| ack_data | input | 1 | Acknowledge value: 1 NACK, 0 ACK |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Byte to transmit |
| baud | input | BAUD_W | Phase length minus one, in system clocks |
| sda_in | input | 1 | Resolved SDA level |
| scl_in | input | 1 | Resolved SCL level |
| sda_lo | output | 1 | Drive SDA low |
| scl_lo | output | 1 | Drive SCL low |
| busy | output | 1 | A sequence is running |
| cmd_bits | output | 5 | Command bit in progress; clears itself when its sequence ends |
| rx_data | output | 8 | Last received byte |
| nack | output | 1 | SDA level sampled in the ninth transmit pulse |
| wcol | output | 1 | Write collision flag |
| done | output | 1 | One-cycle pulse at the end of transmit, receive or acknowledge |

## Verification
Every sequence has a fixed length of N phases. With `baud`=B, `busy` is first 0 after the edge that lies N·(B+1) clocks past the accepting edge. The bench counts every rising edge from the accepting edge up to the falling-edge sample where `busy` reads 0, and expects exactly N·(B+1)+1. It also reads `done` in that same sample. `cmd_bits` and `wcol` are read half a cycle after the accepting edge. A bus monitor samples both lines 2 ns after each rising edge, and a slave model answers within the following low phase. Because of that delay, bit capture and Start/Stop detection see the registered outputs after they settle, even with B=0. For the stretch case the count restarts at the release and is expected to be 15·(B+1), which covers the rest of the stalled phase plus 14 more.

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic              cmd_we,
  input  logic [4:0]        cmd_wdata,
  input  logic              ack_data,
  input  logic              tx_we,
  input  logic [7:0]        tx_data,
  input  logic [BAUD_W-1:0] baud,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_lo,
  output logic              scl_lo,
  output logic              busy,
  output logic [4:0]        cmd_bits,
  output logic [7:0]        rx_data,
  output logic              nack,
  output logic              wcol,
  output logic              done
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_RESTART, S_STOP, S_TX, S_RX, S_ACK} st_t;

  st_t              st, cmd_st;
  logic [4:0]       step, last;
  logic [BAUD_W-1:0] cnt;
  logic [7:0]       sh, rxd;
  logic             ack_lat, scl_hold, sda_hold, nack_q, wcol_q, done_q;
  logic             high, stall;

  assign busy     = (st != S_IDLE);
  assign cmd_bits = {st == S_ACK, st == S_RX, st == S_STOP, st == S_RESTART, st == S_START};
  assign rx_data  = rxd;
  assign nack     = nack_q;
  assign wcol     = wcol_q;
  assign done     = done_q;
  assign high     = busy && !scl_lo;
  assign stall    = high && !scl_in;

  always_comb begin
    cmd_st = S_IDLE;
    if (cmd_wdata[0]) cmd_st = S_START;
    if (cmd_wdata[1]) cmd_st = S_RESTART;
    if (cmd_wdata[2]) cmd_st = S_STOP;
    if (cmd_wdata[3]) cmd_st = S_RX;
    if (cmd_wdata[4]) cmd_st = S_ACK;
  end

  always_comb begin
    case (st)
      S_START, S_ACK: last = 5'd1;
      S_RESTART:      last = 5'd3;
      S_STOP:         last = 5'd2;
      S_TX:           last = 5'd17;
      S_RX:           last = 5'd15;
      default:        last = 5'd0;
    endcase
  end

  always_comb begin
    scl_lo = scl_hold;
    sda_lo = sda_hold;
    case (st)
      S_START:   begin sda_lo = 1'b1; scl_lo = (step == 5'd1); end
      S_RESTART: begin sda_lo = step[1]; scl_lo = (step == 5'd0) || (step == 5'd3); end
      S_STOP:    begin sda_lo = (step != 5'd2); scl_lo = (step == 5'd0); end
      S_TX:      begin scl_lo = !step[0]; sda_lo = (step < 5'd16) ? !sh[7] : 1'b0; end
      S_RX:      begin scl_lo = !step[0]; sda_lo = 1'b0; end
      S_ACK:     begin scl_lo = !step[0]; sda_lo = !ack_lat; end
      default:   ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      step     <= '0;
      cnt      <= '0;
      sh       <= '0;
      rxd      <= '0;
      ack_lat  <= 1'b0;
      scl_hold <= 1'b0;
      sda_hold <= 1'b0;
      nack_q   <= 1'b0;
      wcol_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == S_IDLE) begin
        if (master_en && cmd_we) begin
          if ($onehot(cmd_wdata)) begin
            st      <= cmd_st;
            step    <= '0;
            cnt     <= baud;
            ack_lat <= ack_data;
            wcol_q  <= 1'b0;
          end else begin
            wcol_q <= 1'b1;
          end
        end else if (master_en && tx_we) begin
          st     <= S_TX;
          sh     <= tx_data;
          step   <= '0;
          cnt    <= baud;
          wcol_q <= 1'b0;
        end
      end else begin
        if (master_en && (cmd_we || tx_we)) wcol_q <= 1'b1;
        if (stall) begin
          cnt <= baud;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          if (st == S_RX && step[0]) rxd <= {rxd[6:0], sda_in};
          if (st == S_TX && step[0]) sh <= {sh[6:0], 1'b0};
          if (step == last) begin
            st       <= S_IDLE;
            step     <= '0;
            done_q   <= (st == S_TX) || (st == S_RX) || (st == S_ACK);
            scl_hold <= (st != S_STOP);
            sda_hold <= (st == S_START) || (st == S_RESTART) || (st == S_ACK && !ack_lat);
            if (st == S_TX) nack_q <= sda_in;
          end else begin
            step <= step + 1'b1;
            cnt  <= baud;
          end
        end
      end
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && master_en && cmd_we && $onehot(cmd_wdata) |=> busy && cmd_bits == $past(cmd_wdata));

  p_stop_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(busy) && $past(cmd_bits[2]) |-> !scl_lo && !sda_lo);

  p_tx_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && master_en && !cmd_we && tx_we |=> busy && cmd_bits == 5'd0);

  p_done_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_wcol_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && master_en && (cmd_we || tx_we) |=> wcol);

  p_master_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !master_en |=> !busy && $stable(wcol));

  p_stretch_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !scl_lo && !scl_in |=> busy && $stable(scl_lo) && $stable(sda_lo));

  p_sda_steady_r13: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !scl_lo && $past(!scl_lo) && $stable(cmd_bits) &&
    (cmd_bits[3] || cmd_bits[4] || cmd_bits == 5'd0) |-> $stable(sda_lo));

endmodule

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, master_en, cmd_we, ack_data, tx_we;
  logic [4:0] cmd_wdata;
  logic [7:0] tx_data, baud;
  logic sda_lo, scl_lo, busy, nack, wcol, done;
  logic [4:0] cmd_bits;
  logic [7:0] rx_data;
  logic slave_lo, stretch;
  logic sda_line, scl_line;
  assign sda_line = !(sda_lo || slave_lo);
  assign scl_line = !(scl_lo || stretch);

  i2c_cmd_master #(.BAUD_W(8)) u_i2c_cmd_master (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .ack_data(ack_data), .tx_we(tx_we), .tx_data(tx_data),
    .baud(baud), .sda_in(sda_line), .scl_in(scl_line), .sda_lo(sda_lo),
    .scl_lo(scl_lo), .busy(busy), .cmd_bits(cmd_bits), .rx_data(rx_data),
    .nack(nack), .wcol(wcol), .done(done));

  int nchk = 0, nfail = 0;
  int starts = 0, stops = 0, rises = 0, falls = 0, smode = 0;
  logic [8:0] cap = '0;
  logic [7:0] sbyte = '0;
  logic sack = 1'b0, psda = 1'b1, pscl = 1'b1;

  always @(posedge clk) begin
    #2;
    if (scl_line && pscl && psda && !sda_line) starts++;
    if (scl_line && pscl && !psda && sda_line) stops++;
    if (scl_line && !pscl) begin rises++; cap = {cap[7:0], sda_line}; end
    if (!scl_line && pscl) begin
      falls++;
      if (smode == 1) begin
        if (falls == 8) slave_lo = sack;
        else if (falls == 9) slave_lo = 1'b0;
      end else if (smode == 2) begin
        if (falls < 8) slave_lo = !sbyte[7-falls];
        else slave_lo = 1'b0;
      end
    end
    psda = sda_line;
    pscl = scl_line;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  function automatic int dur(input int phases, input int b);
    return phases * (b + 1) + 1;
  endfunction

  task automatic clr_mon();
    starts = 0; stops = 0; rises = 0; falls = 0;
  endtask

  int n;
  logic [4:0] bits_seen;
  logic done_seen;

  task automatic run(input bit is_tx, input logic [4:0] c, input logic [7:0] d);
    @(negedge clk);
    if (is_tx) begin tx_we = 1'b1; tx_data = d; end
    else begin cmd_we = 1'b1; cmd_wdata = c; end
    @(posedge clk); n = 1;
    @(negedge clk);
    cmd_we = 1'b0; tx_we = 1'b0;
    bits_seen = cmd_bits;
    while (busy && n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
    end
    done_seen = done;
  endtask

  initial begin
    #1500000;
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int b;
    logic [7:0] d;
    void'($urandom(32'd4242));
    rst_n = 1'b0; master_en = 1'b0; cmd_we = 1'b0; cmd_wdata = '0; ack_data = 1'b0;
    tx_we = 1'b0; tx_data = '0; baud = 8'd2; slave_lo = 1'b0; stretch = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!sda_lo && !scl_lo && !busy && cmd_bits == 0 && !wcol && !done && !nack && rx_data == 0,
        "R1 reset state", {busy, cmd_bits, wcol, done}, 0);

    // R10: master mode off
    clr_mon();
    cmd_we = 1'b1; cmd_wdata = 5'b00001;
    @(negedge clk); cmd_we = 1'b0;
    repeat (5) @(negedge clk);
    chk(!busy && !wcol && starts == 0, "R10 ignored when master_en=0", busy, 0);
    master_en = 1'b1;

    // R2 Start
    b = $urandom_range(0, 4); baud = 8'(b); clr_mon();
    run(1'b0, 5'b00001, 8'h00);
    chk(bits_seen == 5'b00001, "R2 cmd bit shown", bits_seen, 1);
    chk(n == dur(2, b), "R11 start length", n, dur(2, b));
    chk(starts == 1 && scl_lo && sda_lo, "R2 start condition and hold", starts, 1);
    chk(!done_seen && cmd_bits == 0, "R8 no done after start", done_seen, 0);

    // R9 collision during transmit
    clr_mon(); smode = 1; sack = 1'b1;
    @(negedge clk); tx_we = 1'b1; tx_data = 8'hC3;
    @(negedge clk); tx_we = 1'b0; cmd_we = 1'b1; cmd_wdata = 5'b00100;
    @(negedge clk); cmd_we = 1'b0;
    chk(wcol == 1'b1, "R9 wcol set on busy write", wcol, 1);
    while (busy) @(negedge clk);
    chk(stops == 0 && scl_lo && cmd_bits == 0, "R9 colliding stop ignored", stops, 0);
    chk(cap[8:1] == 8'hC3 && !nack, "R7 transmit under collision", cap[8:1], 8'hC3);

    // R7 random transmit
    for (int i = 0; i < 6; i++) begin
      b = $urandom_range(0, 4); baud = 8'(b);
      d = 8'($urandom); sack = 1'($urandom);
      clr_mon(); smode = 1;
      run(1'b1, 5'b0, d);
      chk(wcol == 1'b0, "R9 wcol cleared by accepted write", wcol, 0);
      chk(cap[8:1] == d && rises == 9, "R7 transmit bits", cap[8:1], d);
      chk(nack == !sack, "R7 slave ack sampled", nack, !sack);
      chk(n == dur(18, b), "R11 transmit length", n, dur(18, b));
      chk(done_seen, "R8 done after transmit", done_seen, 1);
      chk(starts == 0 && stops == 0, "R13 no condition in transmit", starts + stops, 0);
    end

    // R5 random receive
    for (int i = 0; i < 6; i++) begin
      b = $urandom_range(0, 4); baud = 8'(b);
      sbyte = (i == 0) ? 8'h00 : 8'($urandom);
      clr_mon(); smode = 2; slave_lo = !sbyte[7];
      run(1'b0, 5'b01000, 8'h00);
      chk(bits_seen == 5'b01000, "R5 cmd bit shown", bits_seen, 8);
      chk(rx_data == sbyte, "R5 received byte", rx_data, sbyte);
      chk(n == dur(16, b), "R11 receive length", n, dur(16, b));
      chk(done_seen && cmd_bits == 0, "R8 done after receive", done_seen, 1);
      chk(starts == 0 && stops == 0, "R13 no condition in receive", starts + stops, 0);
    end
    smode = 0; slave_lo = 1'b0;

    // R6 acknowledge both values
    for (int v = 0; v < 2; v++) begin
      b = $urandom_range(0, 3); baud = 8'(b); clr_mon();
      ack_data = 1'(v);
      run(1'b0, 5'b10000, 8'h00);
      chk(cap[0] == 1'(v) && rises == 1, "R6 acknowledge level", cap[0], v);
      chk(n == dur(2, b), "R11 acknowledge length", n, dur(2, b));
      chk(done_seen, "R8 done after acknowledge", done_seen, 1);
    end

    // R9 multi-bit command while idle
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b00011;
    @(negedge clk); cmd_we = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && wcol, "R9 multi-bit command ignored", {busy, wcol}, 1);

    // R3 Repeated Start
    b = $urandom_range(0, 4); baud = 8'(b); clr_mon();
    run(1'b0, 5'b00010, 8'h00);
    chk(bits_seen == 5'b00010 && !wcol, "R3 accepted and wcol cleared", bits_seen, 2);
    chk(starts == 1 && stops == 0 && scl_lo, "R3 repeated start condition", starts, 1);
    chk(n == dur(4, b), "R11 repeated start length", n, dur(4, b));

    // R12 stretch during receive
    b = 2; baud = 8'(b); clr_mon(); stretch = 1'b1;
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b01000;
    @(negedge clk); cmd_we = 1'b0;
    repeat (40) @(negedge clk);
    chk(busy && cmd_bits == 5'b01000 && !scl_lo, "R12 held while SCL low", cmd_bits, 8);
    stretch = 1'b0;
    n = 0;
    while (1) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!busy || n > 5000) break;
    end
    chk(n == 15 * (b + 1), "R12 phase count after release", n, 15 * (b + 1));
    chk(rx_data == 8'hFF, "R5 released bus reads ones", rx_data, 8'hFF);

    // R4 Stop
    b = $urandom_range(0, 4); baud = 8'(b); clr_mon();
    run(1'b0, 5'b00100, 8'h00);
    chk(stops == 1 && starts == 0, "R4 stop condition", stops, 1);
    chk(!scl_lo && !sda_lo && !done_seen, "R4 lines released", {scl_lo, sda_lo}, 0);
    chk(n == dur(3, b), "R11 stop length", n, dur(3, b));

    // R11 minimum phase length
    baud = 8'd0; clr_mon();
    run(1'b0, 5'b00001, 8'h00);
    chk(n == dur(2, 0) && starts == 1, "R11 start with baud 0", n, dur(2, 0));
    clr_mon();
    run(1'b0, 5'b00100, 8'h00);
    chk(n == dur(3, 0) && stops == 1, "R4 stop with baud 0", n, dur(3, 0));

    summary();
    $finish;
  end
endmodule